// File: doc/BRIEF.md
# Addressable Multi-Drop Serial Register Interface

This block is a serial slave that gives a host access to a small register file over three signals: an active-low select, a serial clock and a data line. Up to four copies of the block can share one bus without separate select lines. Two strap inputs give each copy an address. After reset the straps are not used, so every copy accepts every frame and one broadcast write configures all of them. Once the address-match bit in the control register is set, a copy accepts only frames whose address field equals its straps.

A frame has 26 bits and is sent most significant bit first. The data line is sampled on the rising serial clock edge. Bit 25 is read (1) or write (0). Bits 24:23 are the device address. Bits 22:16 are the register index. Bits 15:0 are the data. The slave drives read data after each falling serial clock edge. It drives it either on the shared data line (three-wire) or on a separate output pin (four-wire). The control register can also replace the external enable and mode pins with register bits.

The serial inputs are sampled by the system clock `clk`. They are assumed to be synchronous to it and to have at least three `clk` cycles per serial clock phase.

The frame state machine has six states:
- IDLE: waits for the select. IDLE→HDR when the select is low.
- HDR: shifts in the 10 header bits. On the 10th rising edge it goes to one of three states:
  - HDR→SKIP when the address does not match.
  - HDR→WDAT for a matching write.
  - HDR→RDAT for a matching read.
- WDAT: shifts in the 16 write data bits. WDAT→DONE on the 26th rising edge, which also commits the write.
- RDAT: shifts out the 16 read data bits. RDAT→DONE on the 26th rising edge.
- SKIP and DONE: hold until the select rises.

From any state, a high select returns the machine to IDLE.

Top module: `mdrop_sreg`

## Requirements
- R1: An active-low asynchronous reset, applied at any time (including in the middle of a frame), restores every register to its startup value and releases both data outputs. The startup values are: control register (index 0) = 0; register k (1..7) = k*0x0101. The control register stores only bits 4:0, and its other bits read as 0.
- R2: A 26-bit frame is taken in most significant bit first on rising serial clock edges, with the field layout {rw, addr[1:0], index[6:0], data[15:0]}. A write frame stores its data in the indexed register. A read frame returns the current contents of that register.
- R3: While control bit 0 (address match) is 0, frames are accepted whatever their address field holds and whatever the straps are.
- R4: While control bit 0 is 1, a frame whose address field differs from the straps changes no register and drives no output.
- R5: In three-wire mode (control bit 1 = 0), read data bits 15..0 appear on `sdio_o` with `sdio_oe` high. Each bit changes only after a falling serial clock edge, and bit 15 is driven after the 10th rising edge, so the host can sample every bit on the next rising edge.
- R6: In four-wire mode (control bit 1 = 1), read data appears on `dout_o` with `dout_oe` high, and `sdio_oe` stays low. The two enables are never high together.
- R7: Both output enables go low on the first `clk` edge at which the select is seen high.
- R8: A frame whose select rises before its 26th rising edge changes no register.
- R9: When control bit 2 is 1, `enbl_o` and `mode_o` follow control bits 3 and 4. Otherwise they follow `enbl_pin` and `mode_pin`.
- R10: Indices 8 to 127 hold no register. A write to one of them is discarded, and a read from one returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| sen_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdio_i | input | 1 | Serial data line, input side |
| sdio_o | output | 1 | Serial data line, output value in three-wire reads |
| sdio_oe | output | 1 | Drive enable for the serial data line |
| dout_o | output | 1 | Separate read data pin used in four-wire mode |
| dout_oe | output | 1 | Drive enable for the separate read data pin |
| dev_addr | input | 2 | Strapped device address |
| enbl_pin | input | 1 | External enable control pin |
| mode_pin | input | 1 | External mode control pin |
| enbl_o | output | 1 | Effective enable after software override |
| mode_o | output | 1 | Effective mode after software override |

## Verification
Every serial clock edge is acted on at the first `clk` edge after it. A read bit is therefore valid one cycle after the falling edge. A committed write is visible two cycles after the 26th rising edge, and the output enables drop one cycle after the select rises.

The bench holds each serial clock phase for four `clk` cycles. It samples read bits at the end of the low phase, and it checks the enables and the override outputs several cycles after the select rises. Each check therefore lands after the result is due and before the next stimulus.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WDAT,
        ST_RDAT,
        ST_SKIP,
        ST_DONE
    } frame_state_e;

    localparam int CTL_ADDR_EN  = 0;
    localparam int CTL_FOUR_W   = 1;
    localparam int CTL_SW       = 2;
    localparam int CTL_SW_ENBL  = 3;
    localparam int CTL_SW_MODE  = 4;
    localparam int CTL_W        = 5;

endpackage

// File: rtl/mdrop_edge.sv
module mdrop_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/mdrop_fsm.sv
module mdrop_fsm
    import mdrop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 7,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sen_n,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdi,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              addr_en,
    input  logic [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              drive,
    output logic              sdo
);
    localparam int HDR_W   = 1 + ADDR_W + IDX_W;
    localparam int FRAME_W = HDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    frame_state_e state, next;

    logic [HDR_W-2:0]  hdr_q;
    logic [HDR_W-1:0]  cur_hdr;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-2:0] wsh;
    logic [DATA_W-1:0] rsh;
    logic              hdr_rw;
    logic [ADDR_W-1:0] hdr_addr;
    logic              hit;
    logic              hdr_last;
    logic              frame_last;

    assign cur_hdr    = {hdr_q, sdi};
    assign hdr_rw     = cur_hdr[HDR_W-1];
    assign hdr_addr   = cur_hdr[HDR_W-2 -: ADDR_W];
    assign rd_idx     = cur_hdr[IDX_W-1:0];
    assign hit        = !addr_en || (hdr_addr == dev_addr);
    assign hdr_last   = (cnt == CNT_W'(HDR_W - 1));
    assign frame_last = (cnt == CNT_W'(FRAME_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next;
    end

    always_comb begin
        next = state;
        if (sen_n) begin
            next = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: next = ST_HDR;
                ST_HDR: begin
                    if (rise && hdr_last)
                        next = !hit ? ST_SKIP : (hdr_rw ? ST_RDAT : ST_WDAT);
                end
                ST_WDAT, ST_RDAT: begin
                    if (rise && frame_last) next = ST_DONE;
                end
                ST_SKIP, ST_DONE: next = state;
                default: next = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            hdr_q   <= '0;
            wsh     <= '0;
            rsh     <= '0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
            drive   <= 1'b0;
            sdo     <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (sen_n) begin
                cnt   <= '0;
                drive <= 1'b0;
            end else begin
                unique case (state)
                    ST_HDR: begin
                        if (rise) begin
                            cnt   <= cnt + 1'b1;
                            hdr_q <= cur_hdr[HDR_W-2:0];
                            if (hdr_last) begin
                                wr_idx <= rd_idx;
                                rsh    <= rd_data;
                            end
                        end
                    end
                    ST_WDAT: begin
                        if (rise) begin
                            cnt <= cnt + 1'b1;
                            wsh <= {wsh[DATA_W-3:0], sdi};
                            if (frame_last) begin
                                wr_en   <= 1'b1;
                                wr_data <= {wsh, sdi};
                            end
                        end
                    end
                    ST_RDAT: begin
                        if (rise) cnt <= cnt + 1'b1;
                        if (fall) begin
                            sdo   <= rsh[DATA_W-1];
                            rsh   <= {rsh[DATA_W-2:0], 1'b0};
                            drive <= 1'b1;
                        end
                    end
                    ST_IDLE, ST_SKIP, ST_DONE: ;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdrop_regs.sv
module mdrop_regs
    import mdrop_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [CTL_W-1:0]  ctrl
);
    localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;

    logic [DATA_W-1:0] regs [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        if (k == 0) begin : g_ctl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[k] <= '0;
                else if (wr_en && wr_idx == IDX_W'(k))
                    regs[k] <= {{(DATA_W-CTL_W){1'b0}}, wr_data[CTL_W-1:0]};
            end
        end else begin : g_dat
            localparam logic [DATA_W-1:0] DEF = DATA_W'(k * 257);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[k] <= DEF;
                else if (wr_en && wr_idx == IDX_W'(k))
                    regs[k] <= wr_data;
            end
        end
    end

    assign rd_data = (int'(rd_idx) < NREG) ? regs[rd_idx[AW-1:0]] : '0;
    assign ctrl    = regs[0][CTL_W-1:0];
endmodule

// File: rtl/mdrop_sreg.sv
module mdrop_sreg
    import mdrop_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 7,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sen_n,
    input  logic              sclk,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              dout_o,
    output logic              dout_oe,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              enbl_pin,
    input  logic              mode_pin,
    output logic              enbl_o,
    output logic              mode_o
);
    logic              rise, fall;
    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_en, drive, sdo;
    logic [CTL_W-1:0]  ctrl;
    logic              four_wire;

    mdrop_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sclk (sclk),
        .rise (rise),
        .fall (fall)
    );

    mdrop_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sen_n   (sen_n),
        .rise    (rise),
        .fall    (fall),
        .sdi     (sdio_i),
        .dev_addr(dev_addr),
        .addr_en (ctrl[CTL_ADDR_EN]),
        .rd_data (rd_data),
        .rd_idx  (rd_idx),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .drive   (drive),
        .sdo     (sdo)
    );

    mdrop_regs #(.NREG(NREG), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .rd_idx (rd_idx),
        .rd_data(rd_data),
        .ctrl   (ctrl)
    );

    assign four_wire = ctrl[CTL_FOUR_W];
    assign sdio_o    = sdo;
    assign dout_o    = sdo;
    assign sdio_oe   = drive & ~four_wire;
    assign dout_oe   = drive &  four_wire;
    assign enbl_o    = ctrl[CTL_SW] ? ctrl[CTL_SW_ENBL] : enbl_pin;
    assign mode_o    = ctrl[CTL_SW] ? ctrl[CTL_SW_MODE] : mode_pin;
endmodule

// File: rtl/mdrop_checks.sv
module mdrop_checks (
    input logic clk,
    input logic rst_n,
    input logic sen_n,
    input logic sclk,
    input logic sdio_o,
    input logic sdio_oe,
    input logic dout_oe,
    input logic wr_en
);
    // R7: select high releases both outputs on the next edge
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        sen_n |=> (!sdio_oe && !dout_oe));

    // R6: never both pins driven
    a_r6_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdio_oe && dout_oe));

    // R5: a driven bit changes only after the serial clock has fallen
    a_r5_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sdio_oe && $past(sdio_oe) && !$stable(sdio_o)) |-> !$past(sclk));

    // R2: a commit follows a rising serial edge inside a selected frame
    a_r2_commit_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!$past(sen_n) && $past(sclk)));

    // R8: a commit is never raised while the select is already high
    a_r8_no_commit_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (sen_n && $past(sen_n)) |-> !wr_en);
endmodule

bind mdrop_sreg mdrop_checks u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sen_n  (sen_n),
    .sclk   (sclk),
    .sdio_o (sdio_o),
    .sdio_oe(sdio_oe),
    .dout_oe(dout_oe),
    .wr_en  (wr_en)
);

// File: tb/sim_mdrop_sreg.sv
module sim_mdrop_sreg;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sen_n = 1'b1;
    logic sclk = 1'b0;
    logic sdio_i = 1'b0;
    logic [1:0] dev_addr = 2'd2;
    logic enbl_pin = 1'b0;
    logic mode_pin = 1'b0;
    logic sdio_o, sdio_oe, dout_o, dout_oe, enbl_o, mode_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] mdl [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    mdrop_sreg u0 (
        .clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sclk(sclk), .sdio_i(sdio_i),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .dout_o(dout_o), .dout_oe(dout_oe),
        .dev_addr(dev_addr), .enbl_pin(enbl_pin), .mode_pin(mode_pin),
        .enbl_o(enbl_o), .mode_o(mode_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input bit rw, input logic [1:0] fa, input logic [6:0] idx,
                        input logic [15:0] d, input int nbits,
                        output logic [15:0] rs, output logic [15:0] rd,
                        output bit saw_s, output bit saw_d);
        logic [25:0] fr;
        fr = {rw, fa, idx, d};
        rs = '0; rd = '0; saw_s = 0; saw_d = 0;
        @(negedge clk) sen_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int b = 25; b >= 26 - nbits; b--) begin
            sclk = 1'b0;
            sdio_i = fr[b];
            repeat (4) @(negedge clk);
            if (b < 16) begin
                rs[b] = sdio_o;
                rd[b] = dout_o;
                if (sdio_oe) saw_s = 1;
                if (dout_oe) saw_d = 1;
            end
            sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (2) @(negedge clk);
        sen_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] fa, input logic [6:0] idx, input logic [15:0] d);
        logic [15:0] a, b;
        bit s, t;
        xfer(1'b0, fa, idx, d, 26, a, b, s, t);
    endtask

    task automatic rd3(input logic [1:0] fa, input logic [6:0] idx,
                       output logic [15:0] v, output bit s, output bit t);
        logic [15:0] b;
        xfer(1'b1, fa, idx, 16'h0, 26, v, b, s, t);
    endtask

    task automatic reset_model();
        for (int k = 0; k < NREG; k++) mdl[k] = 16'(k * 257);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, v2;
        bit s, t;
        reset_model();
        repeat (3) @(negedge clk);
        // R1 outputs quiet in reset
        chk("R1 oe during reset", {30'd0, sdio_oe, dout_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 startup contents, R5 three-wire drive, R7 release
        for (int k = 0; k < NREG; k++) begin
            rd3(2'd0, 7'(k), v, s, t);
            chk("R1 default", {16'd0, v}, {16'd0, mdl[k]});
            chk("R5 sdio driven, dout idle", {30'd0, s, t}, 32'd2);
            chk("R7 released", {30'd0, sdio_oe, dout_oe}, 32'd0);
        end

        // R10 out-of-range index
        rd3(2'd0, 7'd100, v, s, t);
        chk("R10 read unmapped", {16'd0, v}, 32'd0);
        wr(2'd0, 7'd100, 16'hBEEF);
        wr(2'd0, 7'd9, 16'h1234);
        rd3(2'd0, 7'd100, v, s, t);
        chk("R10 read after write", {16'd0, v}, 32'd0);
        for (int k = 0; k < NREG; k++) begin
            rd3(2'd0, 7'(k), v, s, t);
            chk("R10 others untouched", {16'd0, v}, {16'd0, mdl[k]});
        end

        // R3 broadcast: any address field accepted
        for (int a = 0; a < 4; a++) begin
            wr(2'(a), 7'(1 + a), 16'(a * 16'h1357 + 16'h2468));
            mdl[1 + a] = 16'(a * 16'h1357 + 16'h2468);
            rd3(2'((a + 1) % 4), 7'(1 + a), v, s, t);
            chk("R3 broadcast write", {16'd0, v}, {16'd0, mdl[1 + a]});
        end

        // R2 walking ones and extremes
        for (int i = 0; i < 16; i++) begin
            wr(2'd2, 7'd5, 16'(1 << i));
            rd3(2'd2, 7'd5, v, s, t);
            chk("R2 walking one", {16'd0, v}, 32'(1 << i));
        end
        wr(2'd2, 7'd6, 16'hFFFF);
        rd3(2'd2, 7'd6, v, s, t);
        chk("R2 all ones", {16'd0, v}, 32'h0000FFFF);
        wr(2'd2, 7'd7, 16'hA5C3);
        rd3(2'd2, 7'd7, v, s, t);
        chk("R2 pattern", {16'd0, v}, 32'h0000A5C3);
        mdl[5] = 16'h8000; mdl[6] = 16'hFFFF; mdl[7] = 16'hA5C3;

        // R8 aborted frames
        xfer(1'b0, 2'd2, 7'd2, 16'h0F0F, 20, v, v2, s, t);
        rd3(2'd2, 7'd2, v, s, t);
        chk("R8 abort at 20 bits", {16'd0, v}, {16'd0, mdl[2]});
        xfer(1'b0, 2'd2, 7'd2, 16'h0F0F, 25, v, v2, s, t);
        rd3(2'd2, 7'd2, v, s, t);
        chk("R8 abort at 25 bits", {16'd0, v}, {16'd0, mdl[2]});

        // R9 software override of enable and mode
        enbl_pin = 1'b0; mode_pin = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 follows pins", {30'd0, enbl_o, mode_o}, 32'd1);
        wr(2'd0, 7'd0, 16'hFFEC);
        rd3(2'd0, 7'd0, v, s, t);
        chk("R1 control keeps 5 bits", {16'd0, v}, 32'h0000000C);
        chk("R9 override active", {30'd0, enbl_o, mode_o}, 32'd2);
        enbl_pin = 1'b1; mode_pin = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 pins ignored", {30'd0, enbl_o, mode_o}, 32'd2);
        wr(2'd0, 7'd0, 16'h0000);
        chk("R9 back to pins", {30'd0, enbl_o, mode_o}, 32'd2);
        mode_pin = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 pins again", {30'd0, enbl_o, mode_o}, 32'd3);

        // R4 address matching: sweep straps and address fields
        wr(2'd3, 7'd0, 16'h0001);
        for (int p = 0; p < 4; p++) begin
            dev_addr = 2'(p);
            for (int a = 0; a < 4; a++) begin
                wr(2'(a), 7'd4, 16'(16'h4000 + p * 16 + a));
                if (a == p) mdl[4] = 16'(16'h4000 + p * 16 + a);
                rd3(2'(p), 7'd4, v, s, t);
                chk("R4 match only", {16'd0, v}, {16'd0, mdl[4]});
            end
            rd3(2'((p + 1) % 4), 7'd4, v, s, t);
            chk("R4 no drive when unmatched", {30'd0, s, t}, 32'd0);
        end

        // R6 four-wire mode
        dev_addr = 2'd1;
        wr(2'd1, 7'd0, 16'h0003);
        xfer(1'b1, 2'd1, 7'd4, 16'h0, 26, v, v2, s, t);
        chk("R6 dout data", {16'd0, v2}, {16'd0, mdl[4]});
        chk("R6 only dout driven", {30'd0, s, t}, 32'd1);
        chk("R7 released four-wire", {30'd0, sdio_oe, dout_oe}, 32'd0);
        xfer(1'b1, 2'd1, 7'd0, 16'h0, 26, v, v2, s, t);
        chk("R6 control readback", {16'd0, v2}, 32'h00000003);

        // R1 reset in the middle of a frame
        wr(2'd1, 7'd0, 16'h0007);
        @(negedge clk) sen_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int b = 0; b < 6; b++) begin
            sclk = ~sclk;
            sdio_i = 1'b1;
            repeat (4) @(negedge clk);
        end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 mid-frame reset outputs", {30'd0, sdio_oe, dout_oe}, 32'd0);
        sclk = 1'b0; sen_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        reset_model();
        enbl_pin = 1'b0; mode_pin = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 override cleared", {30'd0, enbl_o, mode_o}, 32'd0);
        rd3(2'd3, 7'd0, v, s, t);
        chk("R1 control after reset", {16'd0, v}, 32'd0);
        rd3(2'd0, 7'd4, v, s, t);
        chk("R1 reg4 after reset", {16'd0, v}, {16'd0, mdl[4]});
        rd3(2'd2, 7'd1, v, s, t);
        chk("R1 reg1 after reset", {16'd0, v}, {16'd0, mdl[1]});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule